// File: doc/BRIEF.md
# Predecoded Dispatch Allocator

This block sits between a queue of predecoded instructions and the reservation stations. Each instruction arrives with a 5-bit tag that already states how many micro-operations it expands to. The block never decodes the instruction itself. It steers on that count alone. Short instructions are packed into four parallel dispatch slots. Long or flagged instructions are handed to a microcode sequencer, which then feeds the slots group by group until it signals its last group.

Every slot leaves with a valid flag, the program sequence number of its instruction and the index of the micro-operation within that instruction. Slots fill from index 0 upward. All micro-operations of one short instruction always leave together in the same cycle, and instructions leave strictly in the order they arrived. A downstream ready signal freezes the slots, and a flush input discards all queued and in-flight work.

Top module: `dispatch_alloc`

## Requirements
- R1: After reset, all slots are invalid, `mc_req` is low and `in_ready` is high.
- R2: An instruction is kept only if tag bit 4 (end marker) is set and the count field, bits [2:0], is non-zero. Other accepted inputs are dropped and take no sequence number. Kept instructions get consecutive sequence numbers modulo 2^SEQW, starting from 0 after reset.
- R3: A fast instruction has tag bit 3 clear and a count of 1 to 3. Its micro-operations take consecutive slots carrying indices 0 up to count-1 and its own sequence number.
- R4: Slots are filled from the lowest index upward. A fast instruction is never split across cycles. When it does not fit in the slots left in a cycle, it and everything behind it wait for the next cycle.
- R5: An instruction with tag bit 3 set, or with a count of 4 or more, goes to microcode. When it reaches the head of the queue and the slots advance, it is removed. In that same update all slots become invalid, and `mc_req` rises with `mc_seq` and `mc_cnt` giving its sequence number and count.
- R6: While `mc_req` is high, each advance loads slot k from `mc_vld[k]` and `mc_idx`, tagged with `mc_seq`. No queued instruction is removed. `mc_take` marks each advance.
- R7: An advance with `mc_done` high ends the sequence: `mc_req` falls, and fast-path allocation resumes on the next advance.
- R8: While `out_ready` is low, the slot outputs hold their values and nothing is removed from the queue.
- R9: Flush empties the queue, invalidates all slots and ends any microcode sequence at the next clock edge. `in_ready` is low while flush is high.
- R10: Micro-operations leave in program order: sequence numbers never go backwards from slot to slot or from one advance to the next.
- R11: `in_ready` is low exactly when the queue holds DEPTH instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard queued instructions and any microcode sequence |
| in_valid | input | 1 | Predecoded instruction offered |
| in_tag | input | 5 | Predecode tag: [4] end marker, [3] force microcode, [2:0] micro-op count |
| in_ready | output | 1 | Queue can accept an instruction |
| out_ready | input | 1 | Reservation stations take the current slots |
| slot_vld | output | NSLOT | Per-slot valid |
| slot_seq | output | NSLOT*SEQW | Per-slot instruction sequence number |
| slot_idx | output | NSLOT*3 | Per-slot micro-operation index |
| mc_req | output | 1 | Microcode sequence active |
| mc_seq | output | SEQW | Sequence number of the microcoded instruction |
| mc_cnt | output | 3 | Count field of the microcoded instruction |
| mc_take | output | 1 | Current microcode group consumed this cycle |
| mc_vld | input | NSLOT | Microcode group slot valids |
| mc_idx | input | NSLOT*3 | Microcode group micro-operation indices |
| mc_done | input | 1 | Current microcode group is the last |

## Verification
The bench builds the block with DEPTH = 4 and SEQW = 6. The shallow queue fills within a few cycles whenever `out_ready` drops, so the full-queue boundary is exercised often. It also means that only a handful of instructions are ever available for packing. The narrow sequence field wraps many times in a run, so ordering is checked across the wrap from 63 back to 0. Counts of 4 to 7 make the bench sequencer emit both single-group and two-group microcode sequences.

// File: rtl/dispatch_alloc.sv
module dispatch_alloc #(
  parameter int NSLOT = 4,
  parameter int DEPTH = 8,
  parameter int SEQW  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  in_valid,
  input  logic [4:0]            in_tag,
  output logic                  in_ready,
  input  logic                  out_ready,
  output logic [NSLOT-1:0]      slot_vld,
  output logic [NSLOT*SEQW-1:0] slot_seq,
  output logic [NSLOT*3-1:0]    slot_idx,
  output logic                  mc_req,
  output logic [SEQW-1:0]       mc_seq,
  output logic [2:0]            mc_cnt,
  output logic                  mc_take,
  input  logic [NSLOT-1:0]      mc_vld,
  input  logic [NSLOT*3-1:0]    mc_idx,
  input  logic                  mc_done
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam int FAST_MAX = NSLOT - 1;

  logic [2:0]      q_cnt [DEPTH];
  logic            q_mc  [DEPTH];
  logic [SEQW-1:0] q_seq [DEPTH];
  logic [AW-1:0]   rd_ptr, wr_ptr;
  logic [CW-1:0]   q_count;
  logic [SEQW-1:0] next_seq;

  logic            keep, head_mc, enter_mc;
  logic [CW-1:0]   f_pop, pop_n;
  logic [NSLOT-1:0]      f_vld;
  logic [NSLOT*SEQW-1:0] f_seq;
  logic [NSLOT*3-1:0]    f_idx;

  assign in_ready = !flush && (q_count < CW'(DEPTH));
  assign keep     = in_valid && in_ready && in_tag[4] && (in_tag[2:0] != 3'd0);
  assign head_mc  = (q_count != '0) && q_mc[rd_ptr];
  assign enter_mc = out_ready && !mc_req && head_mc;
  assign mc_take  = mc_req && out_ready;
  assign pop_n    = (!out_ready || mc_req) ? '0 : (enter_mc ? CW'(1) : f_pop);

  always_comb begin
    logic [AW-1:0] ix;
    int used;
    logic stop;
    f_vld = '0;
    f_seq = '0;
    f_idx = '0;
    f_pop = '0;
    used  = 0;
    stop  = 1'b0;
    for (int k = 0; k < NSLOT; k++) begin
      ix = rd_ptr + AW'(k);
      if (!stop && (CW'(k) < q_count) && !q_mc[ix] && (used + int'(q_cnt[ix]) <= NSLOT)) begin
        for (int u = 0; u < FAST_MAX; u++) begin
          if (u < int'(q_cnt[ix])) begin
            f_vld[used+u] = 1'b1;
            f_seq[(used+u)*SEQW +: SEQW] = q_seq[ix];
            f_idx[(used+u)*3 +: 3] = 3'(u);
          end
        end
        used  = used + int'(q_cnt[ix]);
        f_pop = f_pop + CW'(1);
      end else begin
        stop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (keep) begin
      q_cnt[wr_ptr] <= in_tag[2:0];
      q_mc[wr_ptr]  <= in_tag[3] || (int'(in_tag[2:0]) > FAST_MAX);
      q_seq[wr_ptr] <= next_seq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      q_count  <= '0;
      next_seq <= '0;
      mc_req   <= 1'b0;
      mc_seq   <= '0;
      mc_cnt   <= '0;
      slot_vld <= '0;
      slot_seq <= '0;
      slot_idx <= '0;
    end else if (flush) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      q_count  <= '0;
      mc_req   <= 1'b0;
      slot_vld <= '0;
    end else begin
      if (keep) begin
        wr_ptr   <= wr_ptr + AW'(1);
        next_seq <= next_seq + SEQW'(1);
      end
      rd_ptr  <= rd_ptr + AW'(pop_n);
      q_count <= q_count + CW'(keep) - pop_n;
      if (out_ready) begin
        if (mc_req) begin
          slot_vld <= mc_vld;
          slot_idx <= mc_idx;
          slot_seq <= {NSLOT{mc_seq}};
          if (mc_done) mc_req <= 1'b0;
        end else if (enter_mc) begin
          slot_vld <= '0;
          mc_req   <= 1'b1;
          mc_seq   <= q_seq[rd_ptr];
          mc_cnt   <= q_cnt[rd_ptr];
        end else begin
          slot_vld <= f_vld;
          slot_seq <= f_seq;
          slot_idx <= f_idx;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH)); // R11
  AST_HOLD_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && !flush) |=> $stable(slot_vld) && $stable(slot_seq) && $stable(slot_idx)); // R8
  AST_MC_ENTRY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mc_req) |-> (slot_vld == '0)); // R5
  AST_MC_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_req && !flush) |=> (q_count >= $past(q_count))); // R6
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!mc_req && slot_vld == '0 && q_count == '0)); // R9
  AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_req && !$past(mc_req)) |-> (((slot_vld + 1'b1) & slot_vld) == '0)); // R4
endmodule

// File: tb/dispatch_alloc_tb.sv
module dispatch_alloc_tb;
  localparam int NSLOT = 4;
  localparam int DEPTH = 4;
  localparam int SEQW  = 6;
  localparam int SMOD  = 1 << SEQW;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [4:0] in_tag = '0;
  logic in_ready, mc_req, mc_take, mc_done;
  logic [NSLOT-1:0] slot_vld, mc_vld;
  logic [NSLOT*SEQW-1:0] slot_seq;
  logic [NSLOT*3-1:0] slot_idx, mc_idx;
  logic [SEQW-1:0] mc_seq;
  logic [2:0] mc_cnt;

  always #5 clk = ~clk;

  dispatch_alloc #(.NSLOT(NSLOT), .DEPTH(DEPTH), .SEQW(SEQW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_tag(in_tag),
    .in_ready(in_ready), .out_ready(out_ready), .slot_vld(slot_vld), .slot_seq(slot_seq),
    .slot_idx(slot_idx), .mc_req(mc_req), .mc_seq(mc_seq), .mc_cnt(mc_cnt),
    .mc_take(mc_take), .mc_vld(mc_vld), .mc_idx(mc_idx), .mc_done(mc_done));

  int mc_pos = 0;
  always_comb begin
    int rem;
    rem = int'(mc_cnt) - mc_pos;
    mc_vld = '0;
    mc_idx = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (k < rem) begin
        mc_vld[k] = 1'b1;
        mc_idx[k*3 +: 3] = 3'(mc_pos + k);
      end
    end
    mc_done = (rem <= NSLOT);
  end

  int mq_seq[$], mq_cnt[$];
  bit mq_mc[$];
  bit m_busy = 0;
  int m_mseq = 0, m_mcnt = 0, m_next = 0;
  bit m_vld[NSLOT];
  int m_seq[NSLOT], m_idx[NSLOT];
  bit last_ready = 1, last_flush = 0, last_mc = 0;
  int prev_seq = -1;

  int checks = 0, errors = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mq_seq.delete(); mq_cnt.delete(); mq_mc.delete();
      m_busy = 0; m_next = 0; mc_pos = 0;
      foreach (m_vld[k]) m_vld[k] = 0;
      last_mc = 0;
    end else begin
      bit acc;
      acc = in_valid && !flush && (mq_seq.size() < DEPTH);
      last_ready = out_ready;
      last_flush = flush;
      if (flush) begin
        mq_seq.delete(); mq_cnt.delete(); mq_mc.delete();
        m_busy = 0;
        foreach (m_vld[k]) m_vld[k] = 0;
        last_mc = 0;
      end else begin
        if (out_ready) begin
          if (m_busy) begin
            for (int k = 0; k < NSLOT; k++) begin
              m_vld[k] = mc_vld[k];
              m_seq[k] = m_mseq;
              m_idx[k] = int'(mc_idx[k*3 +: 3]);
            end
            if (mc_done) m_busy = 0;
            last_mc = 1;
          end else if (mq_seq.size() > 0 && mq_mc[0]) begin
            m_mseq = mq_seq.pop_front(); m_mcnt = mq_cnt.pop_front(); void'(mq_mc.pop_front());
            m_busy = 1;
            foreach (m_vld[k]) m_vld[k] = 0;
            last_mc = 0;
          end else begin
            int used;
            used = 0;
            foreach (m_vld[k]) m_vld[k] = 0;
            while (mq_seq.size() > 0 && !mq_mc[0] && used + mq_cnt[0] <= NSLOT) begin
              for (int u = 0; u < mq_cnt[0]; u++) begin
                m_vld[used+u] = 1;
                m_seq[used+u] = mq_seq[0];
                m_idx[used+u] = u;
              end
              used += mq_cnt[0];
              void'(mq_seq.pop_front()); void'(mq_cnt.pop_front()); void'(mq_mc.pop_front());
            end
            last_mc = 0;
          end
        end
        if (acc && in_tag[4] && in_tag[2:0] != 0) begin
          mq_seq.push_back(m_next);
          mq_cnt.push_back(int'(in_tag[2:0]));
          mq_mc.push_back(in_tag[3] || in_tag[2:0] >= 4);
          m_next = (m_next + 1) % SMOD;
        end
      end
      if (flush || !mc_req) mc_pos = 0;
      else if (mc_take) mc_pos = mc_done ? 0 : mc_pos + NSLOT;
    end
  end

  task automatic compare();
    string rv;
    rv = last_flush ? "R9" : (!last_ready ? "R8" : (last_mc ? "R6" : "R4"));
    chk(in_ready == (!flush && mq_seq.size() < DEPTH), "R11", "in_ready", int'(in_ready),
        int'(!flush && mq_seq.size() < DEPTH));
    chk(mc_req == m_busy, "R5 R7", "mc_req", int'(mc_req), int'(m_busy));
    if (m_busy) begin
      chk(int'(mc_seq) == m_mseq, "R5", "mc_seq", int'(mc_seq), m_mseq);
      chk(int'(mc_cnt) == m_mcnt, "R5", "mc_cnt", int'(mc_cnt), m_mcnt);
    end
    for (int k = 0; k < NSLOT; k++) begin
      chk(slot_vld[k] == m_vld[k], rv, $sformatf("slot_vld[%0d]", k), int'(slot_vld[k]), int'(m_vld[k]));
      if (m_vld[k] && slot_vld[k]) begin
        chk(int'(slot_seq[k*SEQW +: SEQW]) == m_seq[k], "R2 R10", $sformatf("slot_seq[%0d]", k),
            int'(slot_seq[k*SEQW +: SEQW]), m_seq[k]);
        chk(int'(slot_idx[k*3 +: 3]) == m_idx[k], last_mc ? "R6" : "R3", $sformatf("slot_idx[%0d]", k),
            int'(slot_idx[k*3 +: 3]), m_idx[k]);
      end
    end
  endtask

  task automatic drive(input int mode);
    int r;
    r = int'($urandom % 16);
    in_valid = ($urandom % 4) != 0;
    if (mode == 0) in_tag = {1'b1, 1'b0, 3'(1 + $urandom % 3)};
    else if (r == 0) in_tag = {1'b0, 4'($urandom)};
    else if (r == 1) in_tag = {2'b10, 3'd0};
    else if (r < 4) in_tag = {2'b11, 3'(1 + $urandom % 7)};
    else if (r < 7) in_tag = {2'b10, 3'(4 + $urandom % 4)};
    else in_tag = {2'b10, 3'(1 + $urandom % 3)};
    out_ready = (mode == 2) ? (($urandom % 6) == 0) : (($urandom % 5) != 0);
    flush = (mode != 0) && (($urandom % 80) == 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(slot_vld == '0, "R1", "slot_vld", int'(slot_vld), 0);
    chk(mc_req == 1'b0, "R1", "mc_req", int'(mc_req), 0);
    chk(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    for (int ph = 0; ph < 4; ph++) begin
      int n;
      n = (ph == 0) ? 400 : (ph == 2 ? 400 : 1500);
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        compare();
        drive(ph == 3 ? 1 : ph);
      end
    end
    @(negedge clk);
    compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule